// File: doc/BRIEF.md
# Cascaded Interval Timer with Display Clock

This block is a two-stage counter that runs from two clock enables in one clock domain. The first stage is an 8-bit prescaler that counts auxiliary-clock ticks. The second stage is an 8-bit counter whose tick comes from one of three sources: the auxiliary clock, the main clock, or the wrap of the prescaler. The wrap source divides the auxiliary clock by 256.

A single control byte configures the block. The control byte selects the tick source and can freeze the counters. It also picks which bit of the second stage raises the periodic interrupt flag, and which bit of the prescaler drives a square-wave frame clock for a display driver.

Software accesses the control byte, both counters and the flag through a byte-wide register port. The interrupt flag is also brought out on its own pin.

Top module: `basic_timer_cascade`

## Requirements
- R1: Address 0 holds the control byte, and it reads back what was written. After reset it reads 0. Its fields are:
  - bits 2..0: rate
  - bits 4..3: display divider
  - bit 5: cascade
  - bit 6: freeze
  - bit 7: main-select
- R2: The prescaler advances by one on each cycle with `aux_en` high, and wraps from 0xFF to 0x00.
- R3: With main-select=0 and cascade=0, the second stage advances on each `aux_en` cycle, and `main_en` has no effect on it.
- R4: With main-select=1 and cascade=0, the second stage advances on each `main_en` cycle, and `aux_en` has no effect on it.
- R5: With cascade=1, whatever main-select is, the second stage advances once on each prescaler wrap from 0xFF to 0x00, and `main_en` has no effect on it.
- R6: With freeze=1 the prescaler holds its value. With freeze=1 and cascade=1 the second stage also holds its value. With freeze=1 and cascade=0 the second stage keeps counting from its selected source.
- R7: The prescaler reads at address 1 and the second stage reads at address 2. A write to either address loads that counter, and the load overrides a tick in the same cycle.
- R8: The flag is set when second-stage bit `rate` goes from 0 to 1 on a tick. Starting from zero, the first setting comes after 2^rate ticks and later ones come every 2^(rate+1) ticks.
- R9: The flag reads as bit 0 at address 3. Any write to address 3 clears it, but a setting in the same cycle wins over the clear.
- R10: `lcd_clk` equals prescaler bit (4 + display divider) one cycle late. This gives a square wave whose period is 32, 64, 128 or 256 auxiliary ticks for codes 0 to 3.
- R11: `rdata` shows the register at `addr` one cycle after `addr` is presented. `irq` shows the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aux_en | input | 1 | Auxiliary-clock tick enable |
| main_en | input | 1 | Main-clock tick enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Interval flag |
| lcd_clk | output | 1 | Display frame clock |

## Verification
The bench builds the block with its default 8-bit counters, so a full prescaler wrap takes only 256 ticks. Every rate code from 0 to 7 and every display divider code from 0 to 3 can therefore be swept completely. For each code the bench counts the exact tick on which the flag sets and the exact edges of `lcd_clk`. At this size the cascade can also be run through several real wraps, and freezing can be tried right at the 0xFF boundary.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int CTRL_W = 8;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_PRE  = 2'd1;
  localparam logic [1:0] A_CNT2 = 2'd2;
  localparam logic [1:0] A_FLAG = 2'd3;

  typedef struct packed {
    logic       main_sel;
    logic       freeze;
    logic       cascade;
    logic [1:0] lcd_div;
    logic [2:0] rate;
  } bt_ctrl_t;
endpackage

// File: rtl/bt_regs.sv
module bt_regs #(
  parameter int CNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [1:0]             addr,
  input  logic [7:0]             wdata,
  input  logic [CNT_W-1:0]       pre_cnt,
  input  logic [CNT_W-1:0]       cnt2,
  input  logic                   flag,
  output bt_pkg::bt_ctrl_t       ctrl,
  output logic [7:0]             rdata,
  output logic                   ld_pre,
  output logic                   ld_cnt2,
  output logic                   clr_flag
);
  import bt_pkg::*;

  bt_ctrl_t ctrl_q;

  assign ctrl     = ctrl_q;
  assign ld_pre   = wr_en && (addr == A_PRE);
  assign ld_cnt2  = wr_en && (addr == A_CNT2);
  assign clr_flag = wr_en && (addr == A_FLAG);

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_en && addr == A_CTRL) ctrl_q <= bt_ctrl_t'(wdata);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        A_CTRL:  rdata <= 8'(ctrl_q);
        A_PRE:   rdata <= 8'(pre_cnt);
        A_CNT2:  rdata <= 8'(cnt2);
        default: rdata <= {7'd0, flag};
      endcase
    end
  end

  // R1: a control write is visible in the next cycle
  p_ctrl_load_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CTRL) |=> (8'(ctrl_q) == $past(wdata)));
endmodule

// File: rtl/bt_stage1.sv
module bt_stage1 #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i && !hold_i && !ld_i && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (ld_i)            cnt_q <= ld_val_i;
    else if (tick_i && !hold_i) cnt_q <= cnt_q + 1'b1;
  end

  // R2: one step per auxiliary tick, modulo the counter width
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !hold_i && !ld_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  // R6: freeze keeps the prescaler still
  p_freeze_pre_r6: assert property (@(posedge clk) disable iff (rst)
    (hold_i && !ld_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/bt_stage2.sv
module bt_stage2 #(
  parameter int CNT_W  = 8,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aux_i,
  input  logic              main_i,
  input  logic              wrap_i,
  input  logic              main_sel_i,
  input  logic              cascade_i,
  input  logic              freeze_i,
  input  logic              ld_i,
  input  logic [CNT_W-1:0]  ld_val_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              clr_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              flag_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             src, step, rise, flag_q;

  always_comb begin
    if (cascade_i)       src = wrap_i;
    else if (main_sel_i) src = main_i;
    else                 src = aux_i;
    step   = src && !(cascade_i && freeze_i) && !ld_i;
    cnt_nx = cnt_q + 1'b1;
    rise   = step && !cnt_q[rate_i] && cnt_nx[rate_i];
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (ld_i) cnt_q <= ld_val_i;
    else if (step) cnt_q <= cnt_nx;
  end

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (rise)  flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  // R5: in cascade mode only a prescaler wrap moves the second stage
  p_cascade_waits_r5: assert property (@(posedge clk) disable iff (rst)
    (cascade_i && !ld_i && !wrap_i) |=> (cnt_q == $past(cnt_q)));
  // R6: freeze with cascade holds the second stage too
  p_freeze_both_r6: assert property (@(posedge clk) disable iff (rst)
    (cascade_i && freeze_i && !ld_i) |=> (cnt_q == $past(cnt_q)));
  // R8: the flag only rises after some tick source was active
  p_flag_needs_tick_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(aux_i || main_i || wrap_i));
endmodule

// File: rtl/bt_lcd_tap.sv
module bt_lcd_tap #(
  parameter int CNT_W = 8,
  parameter int BASE  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [1:0]       sel_i,
  output logic             lcd_o
);
  localparam int TAPS = 4;
  logic [TAPS-1:0] taps;

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign taps[g] = cnt_i[BASE+g];
  end

  always_ff @(posedge clk) begin
    if (rst) lcd_o <= 1'b0;
    else     lcd_o <= taps[sel_i];
  end
endmodule

// File: rtl/basic_timer_cascade.sv
module basic_timer_cascade #(
  parameter int CNT_W    = 8,
  parameter int LCD_BASE = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       aux_en,
  input  logic       main_en,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       lcd_clk
);
  import bt_pkg::*;

  bt_ctrl_t         ctrl;
  logic [CNT_W-1:0] pre_cnt, cnt2;
  logic             ld_pre, ld_cnt2, clr_flag, wrap, flag;

  bt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pre_cnt(pre_cnt), .cnt2(cnt2), .flag(flag), .ctrl(ctrl), .rdata(rdata),
    .ld_pre(ld_pre), .ld_cnt2(ld_cnt2), .clr_flag(clr_flag)
  );

  bt_stage1 #(.CNT_W(CNT_W)) u_pre (
    .clk(clk), .rst(rst), .tick_i(aux_en), .hold_i(ctrl.freeze),
    .ld_i(ld_pre), .ld_val_i(CNT_W'(wdata)), .cnt_o(pre_cnt), .wrap_o(wrap)
  );

  bt_stage2 #(.CNT_W(CNT_W), .RATE_W(3)) u_cnt2 (
    .clk(clk), .rst(rst), .aux_i(aux_en), .main_i(main_en), .wrap_i(wrap),
    .main_sel_i(ctrl.main_sel), .cascade_i(ctrl.cascade), .freeze_i(ctrl.freeze),
    .ld_i(ld_cnt2), .ld_val_i(CNT_W'(wdata)), .rate_i(ctrl.rate),
    .clr_i(clr_flag), .cnt_o(cnt2), .flag_o(flag)
  );

  bt_lcd_tap #(.CNT_W(CNT_W), .BASE(LCD_BASE)) u_lcd (
    .clk(clk), .rst(rst), .cnt_i(pre_cnt), .sel_i(ctrl.lcd_div), .lcd_o(lcd_clk)
  );

  assign irq = flag;
endmodule

// File: tb/basic_timer_cascade_test.sv
`timescale 1ns/1ps
module basic_timer_cascade_test;
  logic clk = 1'b0, rst = 1'b1;
  logic aux_en = 1'b0, main_en = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq, lcd_clk;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  basic_timer_cascade uut (
    .clk(clk), .rst(rst), .aux_en(aux_en), .main_en(main_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .lcd_clk(lcd_clk)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk); addr = a;
    @(negedge clk); v = int'(rdata);
  endtask

  task automatic aux(input int n);
    if (n > 0) begin
      @(negedge clk); aux_en = 1'b1;
      repeat (n) @(negedge clk);
      aux_en = 1'b0;
    end
  endtask

  task automatic mainp(input int n);
    if (n > 0) begin
      @(negedge clk); main_en = 1'b1;
      repeat (n) @(negedge clk);
      main_en = 1'b0;
    end
  endtask

  task automatic zero_counters();
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1/R11 reset state
    rd(2'd0, v); check("R1 reset ctrl", v, 0);
    rd(2'd1, v); check("R7 reset prescaler", v, 0);
    rd(2'd2, v); check("R7 reset cnt2", v, 0);
    check("R11 reset irq", int'(irq), 0);
    check("R10 reset lcd", int'(lcd_clk), 0);

    // R1 control readback
    wr(2'd0, 8'h5B); rd(2'd0, v); check("R1 ctrl readback", v, 8'h5B);

    // R7 loads
    wr(2'd1, 8'hA5); rd(2'd1, v); check("R7 load prescaler", v, 8'hA5);
    wr(2'd2, 8'h3C); rd(2'd2, v); check("R7 load cnt2", v, 8'h3C);

    // R3 aux source
    wr(2'd0, 8'h00); zero_counters();
    aux(37);
    rd(2'd1, v); check("R2 prescaler count", v, 37);
    rd(2'd2, v); check("R3 cnt2 aux count", v, 37);
    mainp(5);
    rd(2'd2, v); check("R3 main ignored", v, 37);

    // R2 wrap
    wr(2'd1, 8'hFE); aux(3);
    rd(2'd1, v); check("R2 wrap", v, 1);

    // R4 main source
    wr(2'd0, 8'h80); zero_counters();
    mainp(9);
    rd(2'd2, v); check("R4 cnt2 main count", v, 9);
    rd(2'd1, v); check("R4 prescaler untouched by main", v, 0);
    aux(4);
    rd(2'd2, v); check("R4 aux ignored", v, 9);
    rd(2'd1, v); check("R2 prescaler under main sel", v, 4);

    // R5 cascade
    wr(2'd0, 8'h20); zero_counters();
    aux(256*3 + 5);
    rd(2'd2, v); check("R5 cascade wraps", v, 3);
    rd(2'd1, v); check("R5 prescaler residue", v, 5);
    mainp(10);
    rd(2'd2, v); check("R5 main ignored", v, 3);
    wr(2'd0, 8'hA0);
    aux(256);
    rd(2'd2, v); check("R5 cascade with main sel", v, 4);
    mainp(7);
    rd(2'd2, v); check("R5 main ignored both bits", v, 4);

    // R6 freeze without cascade
    wr(2'd0, 8'hC0); wr(2'd1, 8'h11); wr(2'd2, 8'h00);
    aux(10);
    rd(2'd1, v); check("R6 prescaler frozen", v, 8'h11);
    mainp(6);
    rd(2'd2, v); check("R6 cnt2 still counts", v, 6);

    // R6 freeze with cascade at the wrap boundary
    wr(2'd0, 8'h60); wr(2'd1, 8'hFF); wr(2'd2, 8'h07);
    aux(3);
    rd(2'd1, v); check("R6 prescaler frozen at FF", v, 8'hFF);
    rd(2'd2, v); check("R6 cnt2 frozen", v, 7);
    wr(2'd0, 8'h20);
    aux(1);
    rd(2'd1, v); check("R5 release wraps prescaler", v, 0);
    rd(2'd2, v); check("R5 release advances cnt2", v, 8);

    // R8 rate sweep on main source; R9 clear
    for (int r = 0; r < 8; r++) begin
      wr(2'd0, 8'(8'h80 | r)); wr(2'd2, 8'h00); wr(2'd3, 8'h00);
      mainp((1 << r) - 1);
      @(negedge clk); check($sformatf("R8 rate %0d before first", r), int'(irq), 0);
      mainp(1);
      check($sformatf("R8 rate %0d first", r), int'(irq), 1);
      rd(2'd3, v); check($sformatf("R9 rate %0d flag read", r), v, 1);
      wr(2'd3, 8'h00);
      check($sformatf("R9 rate %0d cleared", r), int'(irq), 0);
      mainp((2 << r) - 1);
      @(negedge clk); check($sformatf("R8 rate %0d before second", r), int'(irq), 0);
      mainp(1);
      check($sformatf("R8 rate %0d period", r), int'(irq), 1);
    end

    // R10 display divider sweep
    for (int s = 0; s < 4; s++) begin
      wr(2'd0, 8'(s << 3)); wr(2'd1, 8'h00);
      @(negedge clk);
      check($sformatf("R10 div %0d start", s), int'(lcd_clk), 0);
      aux((16 << s) - 1); @(negedge clk);
      check($sformatf("R10 div %0d low half", s), int'(lcd_clk), 0);
      aux(1); @(negedge clk);
      check($sformatf("R10 div %0d rise", s), int'(lcd_clk), 1);
      aux(16 << s); @(negedge clk);
      check($sformatf("R10 div %0d fall", s), int'(lcd_clk), 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule